// File: doc/BRIEF.md
# Noise Channel and Attenuation Mixer

This block is the fourth voice of a four-voice square-wave sound generator, together with the stage that mixes all four voices. The noise voice is a 16-bit shift register that shifts right. Its own period counter advances it on a shared divided-clock tick.

The register has two modes. White mode feeds back two taps. Periodic mode gates one tap off, and the register then simply rotates a single set bit. Parameters select where feedback enters, which bits are tapped, and whether the second tap is compared with 0 or with 1. A synchronous reseed pulse reloads the start pattern.

The mixer takes the three tone-voice output bits from outside and the noise bit from this block. It turns each voice's 4-bit attenuation code into a level that falls 2 dB per step. It sums the levels of the voices whose bits are high, producing one mono sum and two routed stereo sums. A parameter can negate every sum.

Top module: `noise_chan_mixer`

## Requirements
- R1: While `rst` is high the register loads 0x8000 and the period counter loads 0. On the cycle after reset, `noise_bit` is 0 and all three sums are 0.
- R2: A `tick` with the counter at 0 or 1 is an expiry: the counter reloads `noise_period`. Any other tick decrements the counter by one. With a steady tick and period P ≥ 1, an expiry happens every P ticks. A period of 0 makes every tick an expiry.
- R3: On expiry in white mode (`noise_white` = 1) the register shifts right by one. Bit 15 is set exactly when bit 0 XOR bit 3 of the old value is 1. `noise_bit` is bit 0 of the register.
- R4: In periodic mode (`noise_white` = 0) the feedback is bit 0 alone. Starting from 0x8000, `noise_bit` is high on exactly one expiry in every 16.
- R5: `reseed` loads 0x8000 at the next edge and overrides a shift in that cycle. The counter still follows R2 in that cycle.
- R6: Without `tick` and `reseed`, the register and `noise_bit` hold, whatever the period and mode inputs do.
- R7: Attenuation code k maps to level floor(8191 / 10^(k/10)) for k = 0..14, giving 8191, 6506, 5168, ..., 326. Code 15 gives 0.
- R8: `mix_mono` is the sum of the levels of the voices whose bits are high. Voice c (c = 0..2) uses `tone_on[c]`, voice 3 uses `noise_bit`, and voice c takes its code from `atten[4c+3:4c]`. The sum appears one cycle after the inputs and uses the `noise_bit` value from before that edge.
- R9: `mix_left` sums only the high voices c for which `route[4+c]` is set. `mix_right` sums only the high voices c for which `route[c]` is set. Both have the same one-cycle timing as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Divided-clock enable for the noise counter |
| noise_period | input | 11 | Reload value of the noise period counter |
| noise_white | input | 1 | 1 = white noise, 0 = periodic noise |
| reseed | input | 1 | Synchronous reload of the start pattern |
| tone_on | input | 3 | Output bits of the three tone voices |
| atten | input | 16 | Four 4-bit attenuation codes, voice c at bits 4c+3:4c |
| route | input | 8 | Left enables in bits 7:4, right enables in bits 3:0 |
| noise_bit | output | 1 | Noise voice output (register bit 0) |
| mix_mono | output | 16 | Signed sum of all audible voices |
| mix_left | output | 16 | Signed sum of the left-routed voices |
| mix_right | output | 16 | Signed sum of the right-routed voices |

## Verification
The assertions assume that `tick`, `reseed`, the mode and the period are clean synchronous levels, sampled only at the clock edge. They also assume that the sums stay within 16 signed bits, which holds because four full levels reach only 32764. The stimulus changes every input at the falling edge and keeps the period within 11 bits. It runs ticks back to back and also with gaps, and it puts a reseed in the same cycle as an expiry. This way every expiry, hold and reload case the assertions cover actually occurs.

// File: rtl/nz_pkg.sv
package nz_pkg;

    localparam int NUM_CH = 4;
    localparam int ATT_W  = 4;
    localparam int LVL_W  = 13;
    localparam int SMP_W  = 16;

    typedef logic [ATT_W-1:0]        atten_t;
    typedef logic [LVL_W-1:0]        level_t;
    typedef logic signed [SMP_W-1:0] sample_t;

    typedef enum logic {
        NZ_PERIODIC = 1'b0,
        NZ_WHITE    = 1'b1
    } nz_mode_e;

    typedef struct packed {
        sample_t mono;
        sample_t left;
        sample_t right;
    } mix_t;

    // 2 dB per code step down from a quarter of full scale; top code is silent
    function automatic level_t atten_to_level(atten_t code);
        level_t lv;
        case (code)
            4'd0:    lv = 13'd8191;
            4'd1:    lv = 13'd6506;
            4'd2:    lv = 13'd5168;
            4'd3:    lv = 13'd4105;
            4'd4:    lv = 13'd3260;
            4'd5:    lv = 13'd2590;
            4'd6:    lv = 13'd2057;
            4'd7:    lv = 13'd1634;
            4'd8:    lv = 13'd1298;
            4'd9:    lv = 13'd1031;
            4'd10:   lv = 13'd819;
            4'd11:   lv = 13'd650;
            4'd12:   lv = 13'd516;
            4'd13:   lv = 13'd410;
            4'd14:   lv = 13'd326;
            default: lv = 13'd0;
        endcase
        return lv;
    endfunction

    function automatic sample_t widen_level(level_t lv);
        return sample_t'({{(SMP_W-LVL_W){1'b0}}, lv});
    endfunction

endpackage

// File: rtl/nz_lfsr.sv
module nz_lfsr
    import nz_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int FB_BIT    = 15,
    parameter int TAP1      = 0,
    parameter int TAP2      = 3,
    parameter int XNOR_TAPS = 0,
    parameter int PER_W     = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  nz_mode_e         mode,
    input  logic             reseed,
    input  logic [PER_W-1:0] period,
    output logic             out_bit
);

    localparam logic [WIDTH-1:0] SEED     = WIDTH'(1) << FB_BIT;
    localparam logic             TAP2_REF = (XNOR_TAPS != 0);

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] shifted;
    logic [PER_W-1:0] cnt_q;
    logic             expire;
    logic             second_term;
    logic             feedback;

    assign expire      = tick && (cnt_q <= PER_W'(1));
    assign second_term = (mode == NZ_WHITE) && (state_q[TAP2] != TAP2_REF);
    assign feedback    = state_q[TAP1] ^ second_term;

    always_comb begin
        shifted = state_q >> 1;
        if (feedback) begin
            shifted[FB_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
            cnt_q   <= '0;
        end else begin
            if (reseed) begin
                state_q <= SEED;
            end else if (expire) begin
                state_q <= shifted;
            end
            if (tick) begin
                cnt_q <= expire ? period : cnt_q - PER_W'(1);
            end
        end
    end

    assign out_bit = state_q[0];

endmodule

// File: rtl/nz_mixer.sv
module nz_mixer
    import nz_pkg::*;
#(
    parameter int NEGATE = 0,
    parameter int STEREO = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     chan_on,
    input  atten_t [NUM_CH-1:0]   atten,
    input  logic [2*NUM_CH-1:0]   route,
    output mix_t                  mix_q
);

    level_t  lvl [NUM_CH];
    sample_t sum_m;
    sample_t sum_l;
    sample_t sum_r;
    mix_t    mix_d;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_level
        assign lvl[c] = atten_to_level(atten[c]);
    end

    always_comb begin
        sum_m = '0;
        sum_l = '0;
        sum_r = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (chan_on[c]) begin
                sum_m = sum_m + widen_level(lvl[c]);
                if (route[NUM_CH+c]) sum_l = sum_l + widen_level(lvl[c]);
                if (route[c])        sum_r = sum_r + widen_level(lvl[c]);
            end
        end
    end

    always_comb begin
        if (STEREO != 0) begin
            mix_d.left  = (NEGATE != 0) ? -sum_l : sum_l;
            mix_d.right = (NEGATE != 0) ? -sum_r : sum_r;
        end else begin
            mix_d.left  = (NEGATE != 0) ? -sum_m : sum_m;
            mix_d.right = (NEGATE != 0) ? -sum_m : sum_m;
        end
        mix_d.mono = (NEGATE != 0) ? -sum_m : sum_m;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mix_q <= '0;
        end else begin
            mix_q <= mix_d;
        end
    end

endmodule

// File: rtl/noise_chan_mixer.sv
module noise_chan_mixer
    import nz_pkg::*;
#(
    parameter int PER_W     = 11,
    parameter int LFSR_W    = 16,
    parameter int FB_BIT    = 15,
    parameter int TAP1      = 0,
    parameter int TAP2      = 3,
    parameter int XNOR_TAPS = 0,
    parameter int NEGATE    = 0,
    parameter int STEREO    = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic [PER_W-1:0]          noise_period,
    input  logic                      noise_white,
    input  logic                      reseed,
    input  logic [NUM_CH-2:0]         tone_on,
    input  logic [NUM_CH*ATT_W-1:0]   atten,
    input  logic [2*NUM_CH-1:0]       route,
    output logic                      noise_bit,
    output logic signed [SMP_W-1:0]   mix_mono,
    output logic signed [SMP_W-1:0]   mix_left,
    output logic signed [SMP_W-1:0]   mix_right
);

    atten_t [NUM_CH-1:0] att_arr;
    logic   [NUM_CH-1:0] chan_on;
    mix_t                mix_q;

    assign att_arr = atten;
    assign chan_on = {noise_bit, tone_on};

    nz_lfsr #(
        .WIDTH     (LFSR_W),
        .FB_BIT    (FB_BIT),
        .TAP1      (TAP1),
        .TAP2      (TAP2),
        .XNOR_TAPS (XNOR_TAPS),
        .PER_W     (PER_W)
    ) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (nz_mode_e'(noise_white)),
        .reseed  (reseed),
        .period  (noise_period),
        .out_bit (noise_bit)
    );

    nz_mixer #(
        .NEGATE (NEGATE),
        .STEREO (STEREO)
    ) u_mix (
        .clk     (clk),
        .rst     (rst),
        .chan_on (chan_on),
        .atten   (att_arr),
        .route   (route),
        .mix_q   (mix_q)
    );

    assign mix_mono  = mix_q.mono;
    assign mix_left  = mix_q.left;
    assign mix_right = mix_q.right;

endmodule

// File: rtl/noise_chan_mixer_chk.sv
module nz_lfsr_chk #(
    parameter int WIDTH  = 16,
    parameter int FB_BIT = 15,
    parameter int PER_W  = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             reseed,
    input logic [PER_W-1:0] period,
    input logic [WIDTH-1:0] state_q,
    input logic [PER_W-1:0] cnt_q
);

    localparam logic [WIDTH-1:0] SEED = WIDTH'(1) << FB_BIT;

    // R5: reseed lands the start pattern at the next edge
    assert_reseed_seed_R5: assert property (@(posedge clk) disable iff (rst)
        reseed |=> (state_q == SEED));

    // R3: an expiry moves every bit one place toward bit 0
    assert_shift_right_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !reseed && (cnt_q <= PER_W'(1))) |=>
        (state_q[WIDTH-2:0] == $past(state_q[WIDTH-1:1])));

    // R2: an expiry reloads the counter with the period
    assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && (cnt_q <= PER_W'(1))) |=> (cnt_q == $past(period)));

    // R6: no tick and no reseed means the register holds
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!tick && !reseed) |=> $stable(state_q));

endmodule

module noise_chan_mixer_chk (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         tone_on,
    input logic [15:0]        atten,
    input logic [7:0]         route,
    input logic               noise_bit,
    input logic signed [15:0] mix_mono,
    input logic signed [15:0] mix_left,
    input logic signed [15:0] mix_right
);

    // R1: outputs clear after a reset cycle
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!noise_bit && mix_mono == 16'sd0 && mix_left == 16'sd0 && mix_right == 16'sd0));

    // R7: all codes at 15 silence every sum
    assert_silent_mix_R7: assert property (@(posedge clk) disable iff (rst)
        (atten == 16'hFFFF) |=> (mix_mono == 16'sd0 && mix_left == 16'sd0 && mix_right == 16'sd0));

    // R8: no voice high gives a zero mono sum
    assert_quiet_voices_R8: assert property (@(posedge clk) disable iff (rst)
        (tone_on == 3'b000 && !noise_bit) |=> (mix_mono == 16'sd0));

    // R9: an empty routing mask silences both sides
    assert_route_off_R9: assert property (@(posedge clk) disable iff (rst)
        (route == 8'h00) |=> (mix_left == 16'sd0 && mix_right == 16'sd0));

endmodule

bind nz_lfsr nz_lfsr_chk #(.WIDTH(16), .FB_BIT(15), .PER_W(11)) u_lfsr_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .reseed  (reseed),
    .period  (period),
    .state_q (state_q),
    .cnt_q   (cnt_q)
);

bind noise_chan_mixer noise_chan_mixer_chk u_top_chk (
    .clk       (clk),
    .rst       (rst),
    .tone_on   (tone_on),
    .atten     (atten),
    .route     (route),
    .noise_bit (noise_bit),
    .mix_mono  (mix_mono),
    .mix_left  (mix_left),
    .mix_right (mix_right)
);

// File: tb/noise_chan_mixer_tb.sv
module noise_chan_mixer_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst = 1'b1;
    logic               tick = 1'b0;
    logic [10:0]        noise_period = '0;
    logic               noise_white = 1'b0;
    logic               reseed = 1'b0;
    logic [2:0]         tone_on = '0;
    logic [15:0]        atten = 16'hFFFF;
    logic [7:0]         route = 8'hFF;
    logic               noise_bit;
    logic signed [15:0] mix_mono;
    logic signed [15:0] mix_left;
    logic signed [15:0] mix_right;

    noise_chan_mixer u_dut (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .noise_period (noise_period),
        .noise_white  (noise_white),
        .reseed       (reseed),
        .tone_on      (tone_on),
        .atten        (atten),
        .route        (route),
        .noise_bit    (noise_bit),
        .mix_mono     (mix_mono),
        .mix_left     (mix_left),
        .mix_right    (mix_right)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [15:0] m_lfsr = 16'h8000;
    int          m_cnt  = 0;
    int          hi_count = 0;

    logic  q_bit[$];
    int    q_mono[$];
    int    q_left[$];
    int    q_right[$];
    string q_tag[$];

    function automatic int exp_level(int code);
        if (code == 15) return 0;
        return int'($floor(8191.0 / (10.0 ** (real'(code) / 10.0))));
    endfunction

    task automatic drive(input logic t, input logic [10:0] p, input logic w, input logic rs,
                         input logic [2:0] tn, input logic [15:0] at, input logic [7:0] rt,
                         input string tag);
        logic [3:0] on;
        int mono;
        int left;
        int right;
        logic fb;
        @(negedge clk);
        tick = t; noise_period = p; noise_white = w; reseed = rs;
        tone_on = tn; atten = at; route = rt;
        on = {m_lfsr[0], tn};
        mono = 0; left = 0; right = 0;
        for (int c = 0; c < 4; c++) begin
            if (on[c]) begin
                int l;
                l = exp_level(int'(at[4*c +: 4]));
                mono += l;
                if (rt[4+c]) left += l;
                if (rt[c])   right += l;
            end
        end
        if (t) begin
            if (m_cnt <= 1) begin
                if (!rs) begin
                    fb = m_lfsr[0] ^ (w & m_lfsr[3]);
                    m_lfsr = {fb, m_lfsr[15:1]};
                end
                m_cnt = int'(p);
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        if (rs) m_lfsr = 16'h8000;
        q_bit.push_back(m_lfsr[0]);
        q_mono.push_back(mono);
        q_left.push_back(left);
        q_right.push_back(right);
        q_tag.push_back(tag);
    endtask

    // monitor: compare one expected item per clock, just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_bit.size() > 0) begin
                logic  eb;
                int    em, el, er;
                string tg;
                eb = q_bit.pop_front();
                em = q_mono.pop_front();
                el = q_left.pop_front();
                er = q_right.pop_front();
                tg = q_tag.pop_front();
                n_vec++;
                if (noise_bit !== eb || int'(mix_mono) != em ||
                    int'(mix_left) != el || int'(mix_right) != er) begin
                    n_bad++;
                    $display("FAIL %s: got bit=%0b mono=%0d left=%0d right=%0d, expected bit=%0b mono=%0d left=%0d right=%0d",
                             tg, noise_bit, mix_mono, mix_left, mix_right, eb, em, el, er);
                end
                if (tg == "R4" && noise_bit === 1'b1) hi_count++;
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: state right after reset, nothing audible
        drive(0, 11'd0, 1, 0, 3'b000, 16'hFFFF, 8'hFF, "R1");

        // R7: every attenuation code on voice 0
        for (int k = 0; k < 16; k++)
            drive(0, 11'd0, 1, 0, 3'b001, {12'hFFF, 4'(k)}, 8'hFF, "R7");

        // R8: all tone combinations with distinct codes
        for (int pt = 0; pt < 8; pt++)
            drive(0, 11'd0, 1, 0, 3'(pt), 16'hF530, 8'hFF, "R8");

        // R9: routing masks
        drive(0, 11'd0, 1, 0, 3'b111, 16'h0421, 8'h0F, "R9");
        drive(0, 11'd0, 1, 0, 3'b111, 16'h0421, 8'hF0, "R9");
        drive(0, 11'd0, 1, 0, 3'b111, 16'h0421, 8'h5A, "R9");
        drive(0, 11'd0, 1, 0, 3'b111, 16'h0421, 8'h00, "R9");
        drive(0, 11'd0, 1, 0, 3'b101, 16'h0421, 8'h81, "R9");

        // R5: reseed without tick
        drive(0, 11'd0, 1, 1, 3'b000, 16'h0FFF, 8'hFF, "R5");

        // R3: white noise every tick, noise voice audible
        for (int i = 0; i < 80; i++)
            drive(1, 11'd1, 1, 0, 3'b000, 16'h0FFF, 8'hCC, "R3");

        // R2: longer period, zero period, and gapped ticks
        for (int i = 0; i < 40; i++)
            drive(1, 11'd3, 1, 0, 3'b010, 16'h02F5, 8'hFF, "R2");
        for (int i = 0; i < 20; i++)
            drive(1, 11'd0, 1, 0, 3'b000, 16'h0FFF, 8'hFF, "R2");
        for (int i = 0; i < 40; i++)
            drive(1'(i % 2), 11'd2, 1, 0, 3'b000, 16'h3FFF, 8'h88, "R2");

        // R6: no tick, period and mode toggling
        for (int i = 0; i < 10; i++)
            drive(0, 11'(i * 37), 1'(i % 2), 0, 3'b000, 16'h0FFF, 8'hFF, "R6");

        // R4: periodic mode from the start pattern
        drive(0, 11'd1, 0, 1, 3'b000, 16'h0FFF, 8'hFF, "R5");
        for (int i = 0; i < 48; i++)
            drive(1, 11'd1, 0, 0, 3'b000, 16'h0FFF, 8'hFF, "R4");

        // R5: reseed coinciding with an expiry, counter still reloads
        drive(1, 11'd4, 1, 1, 3'b000, 16'h0FFF, 8'hFF, "R5");
        for (int i = 0; i < 12; i++)
            drive(1, 11'd2, 1, 0, 3'b000, 16'h0FFF, 8'hFF, "R5");

        repeat (3) @(negedge clk);

        // R4: one high output per 16 expiries over 48 expiries
        n_vec++;
        if (hi_count != 3) begin
            n_bad++;
            $display("FAIL R4: got %0d high periodic outputs, expected 3", hi_count);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule